// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block turns one input clock into two slower clocks that share a common phase reference. The first output runs at one half or one quarter of the input rate. The second output runs at one quarter or one sixth of the input rate. Each output has its own ratio select pin. Both outputs come from a single frame counter. That counter wraps once every twelve input edges, which is the least common multiple of every ratio on offer, so the rising edges the two outputs share land on the same input edge.

A freeze input stops both outputs at their present levels. It is sampled on the falling edge of the input clock, so a change can only take effect while the clock is low and no output pulse is ever cut short. An asynchronous, active-high reset puts every flop at a known phase. Several instances released together therefore stay lined up. The frame counter recovers by itself from any out-of-range power-up value. A change on a ratio select is held back until the next frame boundary. At that boundary both outputs are low and about to rise.

Top module: `dual_ratio_divider`

## Requirements
- R1: `out_a` divides `clk_in` by 2 when `sel_a` is 0 and by 4 when `sel_a` is 1, with 50% duty. Each period starts with its high half.
- R2: `out_b` divides `clk_in` by 4 when `sel_b` is 0 and by 6 when `sel_b` is 1, with 50% duty. The divide-by-6 output is high for 3 input cycles and then low for 3.
- R3: The outputs only change on a rising edge of `clk_in`, and only when the freeze value last captured on a falling edge is 0.
- R4: While the captured freeze value is 1, both outputs keep their levels and the frame position does not advance. After the freeze is lifted, the waveform resumes exactly where it stopped.
- R5: `freeze` is captured on the falling edge of `clk_in`. A change made after a falling edge first affects the rising edge that follows the next falling edge.
- R6: While `rst` is 1, both outputs are 0 at once, whatever the clock is doing.
- R7: Once `rst` is released with freeze at 0, both outputs rise together on the first rising edge. They rise together again at the start of every 12-edge frame.
- R8: A change on `sel_a` or `sel_b` is adopted only at a frame boundary, every 12 advancing edges counted from reset, so no output pulse is truncated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Asynchronous active-high reset to the aligned phase |
| freeze | input | 1 | 1 holds both outputs (sampled on the falling edge) |
| sel_a | input | 1 | Ratio select for `out_a`: 0 = /2, 1 = /4 |
| sel_b | input | 1 | Ratio select for `out_b`: 0 = /4, 1 = /6 |
| out_a | output | 1 | Divided clock, /2 or /4 |
| out_b | output | 1 | Divided clock, /4 or /6 |

## Verification
The properties assume the default ratios. They also assume that `freeze`, `sel_a`, `sel_b` and the release of `rst` never change within setup of the clock edge that samples them. The bench changes these inputs three time units after a rising edge, well before the next falling edge. The one exception is the falling-edge capture test, which changes `freeze` one unit after a falling edge. That change still falls far from the following rising edge. Reset is the only input allowed to change at an arbitrary point, because it acts asynchronously.

// File: rtl/dr_div_pkg.sv
package dr_div_pkg;

    // Ratio selects held for the current frame; bit 0 drives output A.
    typedef struct packed {
        logic sel_b;
        logic sel_a;
    } ratio_sel_t;

    localparam int unsigned NUM_TAPS = 2;

    function automatic int unsigned gcd_u(input int unsigned x, input int unsigned y);
        int unsigned a;
        int unsigned b;
        int unsigned t;
        a = x;
        b = y;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int unsigned lcm_u(input int unsigned x, input int unsigned y);
        return (x / gcd_u(x, y)) * y;
    endfunction

    // Level of a divided clock at a given edge index inside its period.
    function automatic logic in_high_half(input int unsigned pos, input int unsigned ratio);
        return (pos % ratio) < (ratio / 2);
    endfunction

endpackage

// File: rtl/dr_hold_sampler.sv
module dr_hold_sampler (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    output logic run_q
);
    // Captured while the clock falls, so gating changes only while clk is low.
    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            run_q <= 1'b1;
        end else begin
            run_q <= ~freeze;
        end
    end
endmodule

// File: rtl/dr_frame_counter.sv
module dr_frame_counter #(
    parameter int unsigned FRAME = 12,
    localparam int unsigned CW = (FRAME > 1) ? $clog2(FRAME) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] pos_next,
    output logic          at_end
);
    logic [CW-1:0] pos;

    // Any value at or past the last slot wraps to zero, so a random
    // power-up state falls back into the frame within one pass.
    always_comb begin
        at_end   = (pos >= CW'(FRAME - 1));
        pos_next = at_end ? '0 : pos + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pos <= CW'(FRAME - 1);
        end else if (adv) begin
            pos <= pos_next;
        end
    end
endmodule

// File: rtl/dr_ratio_tap.sv
module dr_ratio_tap
    import dr_div_pkg::*;
#(
    parameter int unsigned N_LO = 2,
    parameter int unsigned N_HI = 4,
    parameter int unsigned CW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          use_hi,
    input  logic [CW-1:0] pos_next,
    output logic          q
);
    logic lo_lvl;
    logic hi_lvl;
    logic nxt;

    always_comb begin
        lo_lvl = in_high_half(32'(pos_next), N_LO);
        hi_lvl = in_high_half(32'(pos_next), N_HI);
    end

    generate
        if (N_LO == N_HI) begin : g_fixed
            assign nxt = lo_lvl;
        end else begin : g_sel
            assign nxt = use_hi ? hi_lvl : lo_lvl;
        end
    endgenerate

    // Registered level: the output is a flop, never a gated clock net.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= 1'b0;
        end else if (adv) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
    import dr_div_pkg::*;
#(
    parameter int unsigned A_LO = 2,
    parameter int unsigned A_HI = 4,
    parameter int unsigned B_LO = 4,
    parameter int unsigned B_HI = 6
) (
    input  logic clk_in,
    input  logic rst,
    input  logic freeze,
    input  logic sel_a,
    input  logic sel_b,
    output logic out_a,
    output logic out_b
);
    localparam int unsigned FRAME = lcm_u(lcm_u(A_LO, A_HI), lcm_u(B_LO, B_HI));
    localparam int unsigned CW    = (FRAME > 1) ? $clog2(FRAME) : 1;

    logic          run_q;
    logic          frame_wrap;
    logic [CW-1:0] pos_next;
    ratio_sel_t    mode_pin;
    ratio_sel_t    mode_act;
    ratio_sel_t    mode_eff;
    logic [NUM_TAPS-1:0] tap_q;
    logic [NUM_TAPS-1:0] tap_hi;

    dr_hold_sampler u_hold (
        .clk    (clk_in),
        .rst    (rst),
        .freeze (freeze),
        .run_q  (run_q)
    );

    dr_frame_counter #(.FRAME(FRAME)) u_frame (
        .clk      (clk_in),
        .rst      (rst),
        .adv      (run_q),
        .pos_next (pos_next),
        .at_end   (frame_wrap)
    );

    // Ratio selects are sampled only on the edge that starts a frame.
    always_comb begin
        mode_pin.sel_a = sel_a;
        mode_pin.sel_b = sel_b;
        mode_eff       = frame_wrap ? mode_pin : mode_act;
        tap_hi         = {mode_eff.sel_b, mode_eff.sel_a};
    end

    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            mode_act <= '0;
        end else if (run_q && frame_wrap) begin
            mode_act <= mode_pin;
        end
    end

    generate
        for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
            dr_ratio_tap #(
                .N_LO (g == 0 ? A_LO : B_LO),
                .N_HI (g == 0 ? A_HI : B_HI),
                .CW   (CW)
            ) u_tap (
                .clk      (clk_in),
                .rst      (rst),
                .adv      (run_q),
                .use_hi   (tap_hi[g]),
                .pos_next (pos_next),
                .q        (tap_q[g])
            );
        end
    endgenerate

    assign out_a = tap_q[0];
    assign out_b = tap_q[1];
endmodule

// File: rtl/dr_div_checker.sv
module dr_div_checker (
    input logic       clk,
    input logic       rst,
    input logic       out_a,
    input logic       out_b,
    input logic       run,
    input logic       wrap,
    input logic [1:0] mode_eff,
    input logic [1:0] mode_act
);
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |-> (!out_a && !out_b)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(out_a) && $stable(out_b))); // R4

    AST_A_HALF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (run && !mode_eff[0]) |=> (out_a != $past(out_a))); // R1

    AST_FRAME_CORISE: assert property (@(posedge clk) disable iff (rst)
        (run && wrap) |=> (out_a && out_b && !$past(out_a) && !$past(out_b))); // R7

    AST_MODE_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(run && wrap) |=> $stable(mode_act)); // R8
endmodule

bind dual_ratio_divider dr_div_checker u_dr_chk (
    .clk      (clk_in),
    .rst      (rst),
    .out_a    (out_a),
    .out_b    (out_b),
    .run      (run_q),
    .wrap     (frame_wrap),
    .mode_eff (mode_eff),
    .mode_act (mode_act)
);

// File: tb/dual_ratio_divider_bench.sv
module dual_ratio_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_LEN  = 12;

    logic clk_in = 1'b0;
    logic rst    = 1'b1;
    logic freeze = 1'b0;
    logic sel_a  = 1'b0;
    logic sel_b  = 1'b0;
    logic out_a;
    logic out_b;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model built from the requirements.
    int fp     = 0;
    bit mdl_a  = 1'b0;
    bit mdl_b  = 1'b0;
    bit exp_a  = 1'b0;
    bit exp_b  = 1'b0;

    always #(CLK_PERIOD / 2) clk_in = ~clk_in;

    dual_ratio_divider u_dual_ratio_divider (
        .clk_in (clk_in),
        .rst    (rst),
        .freeze (freeze),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .out_a  (out_a),
        .out_b  (out_b)
    );

    task automatic check_bit(input logic act, input bit expv, input string req, input string what);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, expv, $time);
        end
    endtask

    // One advancing edge: selects adopted at the frame start (R8), levels per R1/R2.
    function automatic void model_step();
        int na;
        int nb;
        if (fp == 0) begin
            mdl_a = sel_a;
            mdl_b = sel_b;
        end
        na = mdl_a ? 4 : 2;
        nb = mdl_b ? 6 : 4;
        exp_a = (fp % na) < (na / 2);
        exp_b = (fp % nb) < (nb / 2);
        fp = (fp + 1) % FRAME_LEN;
    endfunction

    task automatic run_edges(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_in);
            if (!freeze) model_step();
            #3;
            check_bit(out_a, exp_a, tag, "out_a");
            check_bit(out_b, exp_b, tag, "out_b");
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        #1;
        check_bit(out_a, 1'b0, "R6", "out_a in reset");
        check_bit(out_b, 1'b0, "R6", "out_b in reset");
        repeat (2) begin
            @(posedge clk_in);
            #3;
            check_bit(out_a | out_b, 1'b0, "R6", "outputs while reset held");
        end
        @(posedge clk_in);
        #1;
        rst = 1'b0;
        fp = 0;
        exp_a = 1'b0;
        exp_b = 1'b0;
    endtask

    task automatic t_ratio_pair(input bit sa, input bit sb);
        sel_a = sa;
        sel_b = sb;
        do_reset();
        @(posedge clk_in);
        model_step();
        #3;
        check_bit(out_a & out_b, 1'b1, "R7", "both rise on first edge");
        run_edges(2 * FRAME_LEN - 1, (sb ? "R2" : "R1"));
        run_edges(FRAME_LEN, "R7");
    endtask

    task automatic t_freeze_hold();
        sel_a = 1'b1;
        sel_b = 1'b1;
        do_reset();
        run_edges(5, "R3");
        freeze = 1'b1;
        run_edges(4, "R4");
        freeze = 1'b0;
        run_edges(15, "R4");
    endtask

    task automatic t_freeze_falling();
        bit ha;
        bit hb;
        sel_a = 1'b0;
        sel_b = 1'b1;
        do_reset();
        run_edges(3, "R5");
        @(negedge clk_in);
        #1 freeze = 1'b1;
        @(posedge clk_in);
        model_step();
        #3;
        check_bit(out_a, exp_a, "R5", "advance after late freeze");
        check_bit(out_b, exp_b, "R5", "advance after late freeze");
        ha = out_a;
        hb = out_b;
        @(posedge clk_in);
        #3;
        check_bit(out_a, ha, "R5", "held a");
        check_bit(out_b, hb, "R5", "held b");
        @(negedge clk_in);
        #1 freeze = 1'b0;
        @(posedge clk_in);
        #3;
        check_bit(out_a, ha, "R5", "still held a");
        check_bit(out_b, hb, "R5", "still held b");
        run_edges(10, "R5");
    endtask

    task automatic t_select_midframe();
        sel_a = 1'b0;
        sel_b = 1'b0;
        do_reset();
        run_edges(5, "R8");
        sel_a = 1'b1;
        sel_b = 1'b1;
        run_edges(7, "R8");
        run_edges(14, "R8");
        sel_a = 1'b0;
        run_edges(15, "R8");
    endtask

    task automatic t_async_reset();
        sel_a = 1'b1;
        sel_b = 1'b0;
        do_reset();
        run_edges(3, "R6");
        rst = 1'b1;
        #1;
        check_bit(out_a, 1'b0, "R6", "out_a async clear");
        check_bit(out_b, 1'b0, "R6", "out_b async clear");
        @(posedge clk_in);
        #1 rst = 1'b0;
        fp = 0;
        run_edges(FRAME_LEN, "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2;
        check_bit(out_a, 1'b0, "R6", "out_a at start");
        check_bit(out_b, 1'b0, "R6", "out_b at start");
        t_ratio_pair(1'b0, 1'b0);
        t_ratio_pair(1'b1, 1'b1);
        t_ratio_pair(1'b0, 1'b1);
        t_ratio_pair(1'b1, 1'b0);
        t_freeze_hold();
        t_freeze_falling();
        t_select_midframe();
        t_async_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule